// File: doc/BRIEF.md
# Branch Trace Message Encoder

This block sits beside a processor's retirement port and turns the stream of retired instructions into compact program-trace messages. Sequential execution produces nothing at the output. Output appears only when control flow breaks: a taken indirect branch, a jump, an interrupt or an exception. Each message states how many instructions were retired since the previous message and where execution went. A debugger that holds the program image can rebuild the complete instruction flow from these messages.

A message is a short series of packets on a valid/ready stream. The series is a 6-bit type code, a 4-bit source identifier, an 8-bit instruction count and a target address. Each packet carries its own bit length, and the last packet of a message is flagged. The address is normally sent as the difference (XOR) from the address of the previous message, so that only its significant low bits are sent. A full-address synchronization message is sent in these cases:
- after reset;
- for exceptions;
- when the instruction count would run past its range;
- after a message had to be dropped.

The block buffers exactly one message. A discontinuity that arrives while that message is still being sent is dropped and reported as an overrun.

Top module: `btm_encoder`

## Requirements
- R1: While no discontinuity occurs and the instruction count stays below 255, `pkt_valid` stays 0, including during and right after reset.
- R2: Every message is four packets in this fixed order. The type code has length 6, the source identifier (parameter `SRC_ID`) has length 4, the instruction count has length 8, and the address comes last. `pkt_last` is 1 only on the address packet. Once a message has started, `pkt_valid` stays 1 until its last packet is accepted.
- R3: A normal discontinuity (`ret_vld & br_vld`, with `br_exc` low and no pending upgrade) gives type code 4. Its address packet carries `br_tgt XOR last`. Its length is the position of the highest set bit plus one, and at least 1.
- R4: A sync message has type code 12, carries the full target, and has length `ADDR_W`. The first message after reset is a sync message, and so is any discontinuity with `br_exc` high.
- R5: The count packet holds the number of instructions retired (`ret_vld` cycles) since the previous accepted message, including the one that caused this message, saturating at 255. The count restarts at 0 whenever a message is accepted.
- R6: A retirement without `br_vld` that brings the count to 255 forces a sync message. That message has count 255 and carries `ret_addr` as its address.
- R7: A message event is accepted when no message is held, or in the cycle where the last packet of the held message is accepted. Any other event is dropped, and `ovr` is 1 for exactly the following cycle.
- R8: After a dropped event, the next accepted message is a sync message.
- R9: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_data`, `pkt_len` and `pkt_last` hold their values.
- R10: The reference for relative addresses is the address carried by the last accepted message, whether that message was sync or normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_vld | input | 1 | One instruction retires this cycle |
| ret_addr | input | ADDR_W | Address of the retiring instruction |
| br_vld | input | 1 | Retiring instruction redirects flow (indirect branch, jump, interrupt) |
| br_exc | input | 1 | The redirect is an exception |
| br_tgt | input | ADDR_W | Target address of the redirect |
| pkt_valid | output | 1 | Packet available |
| pkt_ready | input | 1 | Consumer accepts packet |
| pkt_data | output | ADDR_W | Packet value, right-aligned |
| pkt_len | output | $clog2(ADDR_W+1) | Number of significant bits in pkt_data |
| pkt_last | output | 1 | Final packet of a message |
| ovr | output | 1 | A message event was dropped in the previous cycle |

## Verification
The bench first walks the target through each single-bit difference from the previous address, plus an unchanged target. This separates each possible relative-address length and the zero-difference minimum. A long run of plain retirements shows that the output stays silent and that the count-limit sync fires exactly at 255. A long random phase then mixes dense branches, exceptions and a ready signal that drops half the time. That phase exercises dropping during a stall, acceptance in the final-handshake cycle, and the upgrade after an overrun, each against an arithmetic model kept in the bench.

// File: rtl/btm_pkg.sv
package btm_pkg;
    localparam int CODE_W = 6;
    localparam int SRC_W  = 4;
    localparam int CNT_W  = 8;
    localparam logic [CODE_W-1:0] CODE_REL  = 6'd4;
    localparam logic [CODE_W-1:0] CODE_SYNC = 6'd12;
    typedef enum logic [1:0] {PK_CODE, PK_SRC, PK_CNT, PK_ADDR} pk_e;
endpackage

// File: rtl/btm_icount.sv
module btm_icount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] cnt_plus,
    output logic         at_limit
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    typedef struct packed { logic [W-1:0] cnt; } st_t;
    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        cnt_plus = (s_q.cnt == MAX) ? MAX : s_q.cnt + 1'b1;
        at_limit = (s_q.cnt >= MAX - 1'b1);
        if (clear)     s_d.cnt = '0;
        else if (tick) s_d.cnt = cnt_plus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> s_q.cnt == '0);
    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == MAX && tick && !clear) |=> s_q.cnt == MAX);
endmodule

// File: rtl/btm_relenc.sv
module btm_relenc #(
    parameter int AW = 16,
    parameter int LW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] tgt,
    input  logic [AW-1:0] last,
    input  logic          full,
    output logic [AW-1:0] val,
    output logic [LW-1:0] len
);
    logic [AW-1:0] diff;
    logic [LW-1:0] sig;

    always_comb begin
        diff = tgt ^ last;
        sig  = LW'(1);
        for (int i = 0; i < AW; i++)
            if (diff[i]) sig = LW'(i + 1);
        val = full ? tgt : diff;
        len = full ? LW'(AW) : sig;
    end
endmodule

// File: rtl/btm_msgq.sv
module btm_msgq
    import btm_pkg::*;
#(
    parameter int              AW     = 16,
    parameter int              LW     = $clog2(AW + 1),
    parameter logic [SRC_W-1:0] SRC_ID = 4'h5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             ld_sync,
    input  logic [CNT_W-1:0] ld_cnt,
    input  logic [AW-1:0]    ld_val,
    input  logic [LW-1:0]    ld_len,
    output logic             free,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [AW-1:0]    pkt_data,
    output logic [LW-1:0]    pkt_len,
    output logic             pkt_last
);
    typedef struct packed {
        logic             occ;
        pk_e              idx;
        logic             sync;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    val;
        logic [LW-1:0]    vlen;
    } st_t;
    st_t s_d, s_q;
    logic hs, done;

    always_comb begin
        s_d  = s_q;
        hs   = s_q.occ && pkt_ready;
        done = hs && (s_q.idx == PK_ADDR);
        free = !s_q.occ || done;
        if (load) begin
            s_d.occ  = 1'b1;
            s_d.idx  = PK_CODE;
            s_d.sync = ld_sync;
            s_d.cnt  = ld_cnt;
            s_d.val  = ld_val;
            s_d.vlen = ld_len;
        end else if (done) begin
            s_d.occ = 1'b0;
        end else if (hs) begin
            s_d.idx = pk_e'(s_q.idx + 2'd1);
        end
    end

    always_comb begin
        pkt_valid = s_q.occ;
        pkt_last  = s_q.occ && (s_q.idx == PK_ADDR);
        case (s_q.idx)
            PK_CODE: begin
                pkt_data = AW'(s_q.sync ? CODE_SYNC : CODE_REL);
                pkt_len  = LW'(CODE_W);
            end
            PK_SRC: begin
                pkt_data = AW'(SRC_ID);
                pkt_len  = LW'(SRC_W);
            end
            PK_CNT: begin
                pkt_data = AW'(s_q.cnt);
                pkt_len  = LW'(CNT_W);
            end
            default: begin
                pkt_data = s_q.val;
                pkt_len  = s_q.vlen;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_data)
                                      && $stable(pkt_len) && $stable(pkt_last));
    // R2
    msg_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && !pkt_last) |=> pkt_valid);
endmodule

// File: rtl/btm_encoder.sv
module btm_encoder
    import btm_pkg::*;
#(
    parameter int               ADDR_W = 16,
    parameter logic [SRC_W-1:0] SRC_ID = 4'h5,
    localparam int              LEN_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_vld,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              br_vld,
    input  logic              br_exc,
    input  logic [ADDR_W-1:0] br_tgt,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [ADDR_W-1:0] pkt_data,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_last,
    output logic              ovr
);
    typedef struct packed {
        logic [ADDR_W-1:0] last;
        logic              sync_pend;
        logic              ovr;
    } st_t;
    st_t s_d, s_q;

    logic              ev_br, ev_of, ev, load, free, full, at_limit;
    logic [ADDR_W-1:0] tgt_sel, enc_val;
    logic [LEN_W-1:0]  enc_len;
    logic [CNT_W-1:0]  cnt_plus;

    btm_icount #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(ret_vld), .clear(load),
        .cnt_plus(cnt_plus), .at_limit(at_limit)
    );

    btm_relenc #(.AW(ADDR_W), .LW(LEN_W)) u_rel (
        .tgt(tgt_sel), .last(s_q.last), .full(full),
        .val(enc_val), .len(enc_len)
    );

    btm_msgq #(.AW(ADDR_W), .LW(LEN_W), .SRC_ID(SRC_ID)) u_q (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_sync(full),
        .ld_cnt(cnt_plus), .ld_val(enc_val), .ld_len(enc_len),
        .free(free), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_data(pkt_data), .pkt_len(pkt_len), .pkt_last(pkt_last)
    );

    always_comb begin
        s_d     = s_q;
        ev_br   = ret_vld && br_vld;
        ev_of   = ret_vld && !br_vld && at_limit;
        ev      = ev_br || ev_of;
        load    = ev && free;
        full    = s_q.sync_pend || (br_vld && br_exc) || ev_of;
        tgt_sel = ev_br ? br_tgt : ret_addr;
        s_d.ovr = ev && !free;
        if (load) begin
            s_d.last      = tgt_sel;
            s_d.sync_pend = 1'b0;
        end else if (ev) begin
            s_d.sync_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.last      <= '0;
            s_q.sync_pend <= 1'b1;
            s_q.ovr       <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ovr = s_q.ovr;

    initial begin
        // R2
        addr_width_chk: assert (ADDR_W >= CNT_W);
    end

    // R7
    ovr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> $past(pkt_valid));
    // R1
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> $past(ret_vld));
    // R8
    upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> s_q.sync_pend);
endmodule

// File: tb/tb_btm_encoder.sv
module tb_btm_encoder;
    localparam int   AW     = 16;
    localparam int   LW     = $clog2(AW + 1);
    localparam logic [3:0] SRC = 4'h5;
    localparam time  PERIOD = 10ns;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          ret_vld = 0, br_vld = 0, br_exc = 0, pkt_ready = 0;
    logic [AW-1:0] ret_addr = '0, br_tgt = '0;
    logic          pkt_valid, pkt_last, ovr;
    logic [AW-1:0] pkt_data;
    logic [LW-1:0] pkt_len;

    int errors = 0, checks = 0;

    btm_encoder #(.ADDR_W(AW), .SRC_ID(SRC)) dut (
        .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_addr(ret_addr),
        .br_vld(br_vld), .br_exc(br_exc), .br_tgt(br_tgt),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
        .pkt_len(pkt_len), .pkt_last(pkt_last), .ovr(ovr)
    );

    always #(PERIOD/2) clk = ~clk;

    // model state
    bit            m_occ, m_sync, m_ovr;
    int            m_idx, m_cnt;
    logic [AW-1:0] m_last;
    longint        e_data[4];
    int            e_len[4];
    string         m_tag;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sig_len(logic [AW-1:0] x);
        int n = 1;
        for (int i = 0; i < AW; i++) if (x[i]) n = i + 1;
        return n;
    endfunction

    task automatic model_reset();
        m_occ = 0; m_sync = 1; m_ovr = 0; m_idx = 0; m_cnt = 0; m_last = '0;
        m_tag = "R1";
    endtask

    // one cycle: check at negedge, drive, advance model, wait for the edge
    task automatic cyc(bit r, logic [AW-1:0] a, bit b, bit e,
                       logic [AW-1:0] t, bit rd);
        bit hs, done, fr, evb, evo, ev, full;
        int ncnt;
        logic [AW-1:0] tg;
        chk(pkt_valid === m_occ, "R7 valid", pkt_valid, m_occ);   // also R1
        chk(ovr === m_ovr, "R7 ovr", ovr, m_ovr);
        if (m_occ) begin
            // R2 framing, R5 count (idx 2), R3/R4/R6/R8 by message kind
            chk(pkt_data === AW'(e_data[m_idx]), m_idx == 2 ? "R5 count" : m_tag,
                pkt_data, e_data[m_idx]);
            chk(pkt_len === LW'(e_len[m_idx]), "R2 len", pkt_len, e_len[m_idx]);
            chk(pkt_last === (m_idx == 3), "R2 last", pkt_last, m_idx == 3);
        end
        ret_vld = r; ret_addr = a; br_vld = b; br_exc = e; br_tgt = t; pkt_ready = rd;
        hs   = m_occ && rd;
        done = hs && m_idx == 3;
        fr   = !m_occ || done;
        evb  = r && b;
        evo  = r && !b && m_cnt >= 254;
        ev   = evb || evo;
        ncnt = (m_cnt == 255) ? 255 : m_cnt + 1;
        m_ovr = ev && !fr;
        if (ev && fr) begin
            full = m_sync || (b && e) || evo;
            tg   = evb ? t : a;
            m_tag = evo ? "R6" : (b && e) ? "R4 exc" : m_sync ? "R4/R8 sync" : "R3 rel";
            e_data[0] = full ? 12 : 4;     e_len[0] = 6;
            e_data[1] = SRC;               e_len[1] = 4;
            e_data[2] = ncnt;              e_len[2] = 8;
            e_data[3] = full ? tg : (tg ^ m_last);           // R10 reference
            e_len[3]  = full ? AW : sig_len(tg ^ m_last);
            m_last = tg; m_cnt = 0; m_sync = 0; m_occ = 1; m_idx = 0;
        end else begin
            if (done) m_occ = 0;
            else if (hs) m_idx++;
            if (r) m_cnt = ncnt;
            if (ev) m_sync = 1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, '0, 1);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] pc;
        model_reset();
        repeat (3) @(negedge clk);
        chk(pkt_valid === 1'b0, "R1 reset", pkt_valid, 0);
        rst_n = 1'b1;
        // R1: plain retirement is silent
        pc = 16'h0100;
        for (int i = 0; i < 50; i++) begin cyc(1, pc, 0, 0, '0, 1); pc += 2; end
        // R4: first message after reset is sync
        cyc(1, pc, 1, 0, 16'h1234, 1); idle(6);
        // R3/R10: every single-bit difference and the zero difference
        for (int b = 0; b < AW; b++) begin
            for (int k = 0; k < b % 3; k++) cyc(1, pc, 0, 0, '0, 1);
            cyc(1, pc, 1, 0, m_last ^ (AW'(1) << b), 1); idle(5);
            cyc(1, pc, 1, 0, m_last, 1); idle(5);
        end
        // R4: exception
        cyc(1, pc, 1, 1, 16'h0800, 1); idle(5);
        cyc(1, pc, 1, 0, 16'h0803, 1); idle(5);
        // R6: count limit forces sync
        for (int i = 0; i < 300; i++) begin cyc(1, pc, 0, 0, '0, 1); pc += 4; end
        idle(6);
        // R7/R8/R9: back-pressure with dense events
        for (int i = 0; i < 6000; i++) begin
            bit r, b, e, rd;
            r  = $urandom_range(0, 9) < 7;
            b  = $urandom_range(0, 9) < 3;
            e  = $urandom_range(0, 29) == 0;
            rd = $urandom_range(0, 1) == 1;
            cyc(r, AW'($urandom), b, e, m_last ^ AW'($urandom_range(0, 4095)), rd);
        end
        idle(8);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule